// File: doc/BRIEF.md
# Refresh Interval Timer

This block is an 8-bit up-counter paced by one of several divided versions of the system clock. Its count is checked against a programmable compare value on every counting step. When the two are equal the counter returns to zero and a sticky match flag is raised. Software can route the flag to an interrupt line. When refresh mode is on, each match also sends a one-cycle request to the memory refresh arbiter. When refresh mode is off, the same hardware is a plain interval timer.

Software reaches the block through a small register port. A write strobe, a read strobe and a 2-bit address select one of three byte registers: control/status, counter and compare. Reads are combinational from the address. Counting starts on the first clock after a nonzero divider code is written. The counter and the compare value can be rewritten at any time, so software can restart an interval or change its length.

Top module: `rct_timer`

## Requirements
- R1: Each divided-clock enable adds 1 to the counter, unless the count equals the compare value. The count goes from 0xFF back to 0x00.
- R2: The divider code sits in control bits [2:0]. Code 0 holds the counter still. Codes 1 to 7 make the counter step once every 2, 8, 32, 128, 512, 2048 and 4096 clock cycles. These enables come from a free-running prescaler that starts at reset.
- R3: If the count equals the compare value on an enable, the counter goes to 0x00 and the match flag (control bit 5) is set. The interval from one match to the next is therefore divisor × (compare + 1) cycles.
- R4: If the count is above the compare value, the counter runs up through 0xFF and 0x00. The flag is not raised until an actual equality.
- R5: When refresh enable (control bit 4) is 0, refreshReq never goes high. When it is 1, every match drives refreshReq high for exactly one cycle, in the cycle after the match.
- R6: The irq output is the match flag ANDed with the interrupt enable (control bit 3). It follows changes in either one.
- R7: The flag is cleared only by a control write with bit 5 at 0 that comes after a control read showing the flag at 1, with no other control write in between. A write of 0 without that read leaves the flag set. A write of 1 to a clear flag does not set it.
- R8: If software writes the counter in the same cycle as an enable, the written value is loaded and the increment is dropped.
- R9: Register map: address 0 is control/status, address 1 is the counter, address 2 is compare, and address 3 reads 0x00. After reset, every register and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (arms flag clearing) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| matchFlag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Match interrupt request |
| refreshReq | output | 1 | One-cycle refresh request pulse |

## Verification
A wrong count or a wrong prescaler phase shows up as a wrong gap between refreshReq pulses. That error appears within one programmed interval, at most divisor × 256 cycles. A wrong compare path shows up differently: the flag either never rises during a wrap, or rises before the count has passed through 0xFF. A wrong clear-arm state shows up at once as a matchFlag or irq level that does not match the read/write history. A loss of write priority shows up in the counter readback one cycle after the write.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 3;
  localparam int NUM_DIV = (1 << SEL_W) - 1;
  localparam int PRE_W   = 12;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;

  localparam int IEN_BIT  = 3;
  localparam int RFEN_BIT = 4;
  localparam int FLAG_BIT = 5;

  // log2 of the divisor for each select code (1..NUM_DIV)
  function automatic int divExp(input int code);
    return (code == NUM_DIV) ? PRE_W : 2 * code - 1;
  endfunction

  typedef struct packed {
    logic             tick;
    logic             cntLoad;
    logic             cmpLoad;
    logic [CNT_W-1:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/rct_prescale.sv
module rct_prescale
  import rct_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  output logic [NUM_DIV:0]   tickVec
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign tickVec[0] = 1'b0;

  for (genvar k = 1; k <= NUM_DIV; k++) begin : g_tick
    localparam int E = divExp(k);
    assign tickVec[k] = &preCnt[E-1:0];
  end
endmodule

// File: rtl/rct_datapath.sv
module rct_datapath
  import rct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             matchPulse
);
  assign matchPulse = strobe.tick && !strobe.cntLoad && (cntVal == cmpVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
      cmpVal <= '0;
    end else begin
      if (strobe.cntLoad)   cntVal <= strobe.wrData;
      else if (matchPulse)  cntVal <= '0;
      else if (strobe.tick) cntVal <= cntVal + 1'b1;
      if (strobe.cmpLoad)   cmpVal <= strobe.wrData;
    end
  end

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> (cntVal == '0)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.cntLoad && cntVal != cmpVal) |=> (cntVal == $past(cntVal) + 1'b1)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.cntLoad) |=> $stable(cntVal)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> (cntVal == $past(strobe.wrData))); // R8
endmodule

// File: rtl/rct_ctrl.sv
module rct_ctrl
  import rct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  input  logic [NUM_DIV:0] tickVec,
  input  logic             matchPulse,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] cmpVal,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] regRdData,
  output logic             matchFlag,
  output logic             irq,
  output logic             refreshReq
);
  logic [SEL_W-1:0] clkSel;
  logic             intEn;
  logic             refreshEn;
  logic             clrArm;
  logic             ctrlWr;
  logic             ctrlRd;
  logic [CNT_W-1:0] ctrlByte;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign ctrlRd = regRdEn && (regAddr == ADDR_CTRL);

  assign strobe.tick    = tickVec[clkSel];
  assign strobe.cntLoad = regWrEn && (regAddr == ADDR_CNT);
  assign strobe.cmpLoad = regWrEn && (regAddr == ADDR_CMP);
  assign strobe.wrData  = regWrData;

  always_comb begin
    ctrlByte = '0;
    ctrlByte[SEL_W-1:0] = clkSel;
    ctrlByte[IEN_BIT]   = intEn;
    ctrlByte[RFEN_BIT]  = refreshEn;
    ctrlByte[FLAG_BIT]  = matchFlag;
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlByte;
      ADDR_CNT:  regRdData = cntVal;
      ADDR_CMP:  regRdData = cmpVal;
      default:   regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel     <= '0;
      intEn      <= 1'b0;
      refreshEn  <= 1'b0;
      matchFlag  <= 1'b0;
      clrArm     <= 1'b0;
      refreshReq <= 1'b0;
    end else begin
      refreshReq <= matchPulse && refreshEn;
      if (ctrlWr) begin
        clkSel    <= regWrData[SEL_W-1:0];
        intEn     <= regWrData[IEN_BIT];
        refreshEn <= regWrData[RFEN_BIT];
      end
      if (matchPulse)
        matchFlag <= 1'b1;
      else if (ctrlWr && !regWrData[FLAG_BIT] && clrArm)
        matchFlag <= 1'b0;
      if (ctrlWr)                  clrArm <= 1'b0;
      else if (ctrlRd && matchFlag) clrArm <= 1'b1;
    end
  end

  assign irq = matchFlag && intEn;

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> matchFlag); // R3
  AST_NO_REFRESH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !refreshEn |=> !refreshReq); // R5
  AST_REFRESH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |=> !refreshReq); // R5
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !clrArm) |=> matchFlag); // R7
endmodule

// File: rtl/rct_timer.sv
module rct_timer
  import rct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       matchFlag,
  output logic       irq,
  output logic       refreshReq
);
  logic [NUM_DIV:0] tickVec;
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic             matchPulse;

  rct_prescale u_pre (.clk(clk), .rstN(rstN), .tickVec(tickVec));

  rct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .tickVec(tickVec),
    .matchPulse(matchPulse), .cntVal(cntVal), .cmpVal(cmpVal),
    .strobe(strobe), .regRdData(regRdData), .matchFlag(matchFlag),
    .irq(irq), .refreshReq(refreshReq)
  );

  rct_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntVal(cntVal),
    .cmpVal(cmpVal), .matchPulse(matchPulse)
  );
endmodule

// File: tb/tb_rct_timer.sv
module tb_rct_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       matchFlag, irq, refreshReq;
  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2;
  localparam int NV = 6;
  localparam int VSEL [NV] = '{1, 1, 2, 3, 1, 4};
  localparam int VCMP [NV] = '{3, 0, 4, 1, 255, 2};
  localparam int VPER [NV] = '{8, 2, 40, 64, 512, 384};

  rct_timer dut (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .matchFlag(matchFlag), .irq(irq), .refreshReq(refreshReq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 v = regRdData;
    @(posedge clk); #1 regRdEn = 1'b0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    @(negedge clk);
    while (!refreshReq && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(4 * 200000);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, prev, cur;
    int n, seen;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9 reset state
    rd(A_CTRL, v); chk("R9 ctrl", v, 0);
    rd(A_CNT, v);  chk("R9 cnt", v, 0);
    rd(A_CMP, v);  chk("R9 cmp", v, 0);
    rd(2'd3, v);   chk("R9 addr3", v, 0);
    chk("R9 outputs", {matchFlag, irq, refreshReq}, 0);

    // R2/R3 table: period between refresh pulses
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 8'h20);
      wr(A_CNT, 8'h00);
      wr(A_CMP, 8'(VCMP[i]));
      wr(A_CTRL, 8'(8'h30 | VSEL[i]));
      waitPulse(n);
      waitPulse(n);
      chk($sformatf("R2 R3 period vec%0d", i), n + 1, VPER[i]);
      chk("R3 flag set", matchFlag, 1);
    end

    // R7 / R6 flag handling
    wr(A_CTRL, 8'h20);            // stop, flag bit 1
    wr(A_CTRL, 8'h00);            // clear attempt without read
    chk("R7 no clear without read", matchFlag, 1);
    chk("R6 irq gated off", irq, 0);
    wr(A_CTRL, 8'h28);            // enable interrupt
    @(negedge clk); chk("R6 irq on", irq, 1);
    rd(A_CTRL, v); chk("R9 R7 flag readback", v, 8'h28);
    wr(A_CTRL, 8'h08);            // armed clear
    @(negedge clk);
    chk("R7 cleared", matchFlag, 0);
    chk("R6 irq follows", irq, 0);
    wr(A_CTRL, 8'h28);
    @(negedge clk); chk("R7 write one no set", matchFlag, 0);

    // R2 stop
    wr(A_CTRL, 8'h00);
    wr(A_CNT, 8'h55);
    repeat (50) @(negedge clk);
    rd(A_CNT, v); chk("R2 stopped", v, 8'h55);

    // R4 / R5 wrap with refresh off
    wr(A_CMP, 8'd3);
    wr(A_CNT, 8'd10);
    wr(A_CTRL, 8'h09);
    seen = 0;
    for (int c = 0; c < 480; c++) begin
      @(negedge clk); if (refreshReq) seen++;
    end
    chk("R4 no early flag", matchFlag, 0);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk); if (refreshReq) seen++;
    end
    chk("R4 flag after wrap", matchFlag, 1);
    chk("R6 irq after wrap", irq, 1);
    chk("R5 no refresh when off", seen, 0);

    // R8 / R1 write priority on a tick cycle
    wr(A_CTRL, 8'h00);
    wr(A_CMP, 8'hFF);
    wr(A_CNT, 8'h20);
    wr(A_CTRL, 8'h01);
    @(negedge clk); regAddr = A_CNT; #1 prev = regRdData; cur = prev;
    for (int c = 0; c < 8 && cur == prev; c++) begin
      @(negedge clk); #1 cur = regRdData;
      if (cur == prev) prev = cur;
    end
    chk("R1 step", cur, 8'(prev + 1));
    @(negedge clk);
    regAddr = A_CNT; regWrData = 8'h90; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
    @(negedge clk); #1 chk("R8 write beats tick", regRdData, 8'h90);
    @(negedge clk); @(negedge clk); #1 chk("R1 next step", regRdData, 8'h91);

    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule